// File: doc/BRIEF.md
# Character Display Command Sequencer

This block brings up a character LCD controller after reset and then writes a fixed text message to it. It plays a fixed list of 10-bit entries in order. The top two bits of each entry pick the kind of bus write, and the low byte goes onto the 8-bit data bus. For each entry the block sets up the bus, pulses the enable line for a set number of cycles, and then waits a settle period before it moves on. Entries that clear the screen or send the cursor home are slow on the display side, so they get a longer wait.

The list always has the same shape. Four set-up instructions come first: function set, display on with cursor and blink off, clear, and cursor home. The message characters follow as data writes, and an optional shift-left instruction closes the list. An internal pointer walks the list. When it steps one past the final entry the block raises `done` and holds it until the next reset. Reading the busy flag and the 4-bit bus mode are not supported; every wait is counted in clock cycles.

Top module: `lcd_cmd_sequencer`

## Requirements
- R1: While reset is held (and straight after it), `lcd_en` and `done` are low and the bus shows the first entry: `lcd_data`=0x3C, `lcd_rs`=0, `lcd_rw`=0.
- R2: Each entry is 10 bits. Bit 9 drives `lcd_rs` and bit 8 drives `lcd_rw`. Bits 7:0 drive `lcd_data`. Instruction entries use prefix 00 and character entries use prefix 10.
- R3: The entries play in this order: 0x3C, 0x0C, 0x01, 0x02, then the message bytes from first character to last (the first character is the most significant byte of `MSG`), then 0x18 when `TAIL_SHIFT` is 1.
- R4: For every entry, `lcd_en` is high for exactly `STROBE_CYCLES` consecutive cycles.
- R5: Before each rise of `lcd_en`, the bus holds the new entry with `lcd_en` low for `SETUP_CYCLES` cycles.
- R6: `lcd_data`, `lcd_rs` and `lcd_rw` do not change while `lcd_en` is high.
- R7: After an ordinary entry, `lcd_en` stays low for `SETTLE_CYCLES` + `SETUP_CYCLES` cycles before the next rise.
- R8: After an instruction entry whose byte is 0x01, 0x02 or 0x03, the low gap is `LONG_SETTLE_CYCLES` + `SETUP_CYCLES` cycles instead.
- R9: `done` rises `SETTLE_CYCLES` cycles after the final strobe falls. It then stays high with `lcd_en` low until reset.
- R10: A reset applied in the middle of the sequence restarts it from the first entry, with full set-up and strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lcd_rs | output | 1 | Register select: 1 for a character write, 0 for an instruction |
| lcd_rw | output | 1 | Read/write line; always 0 (write) in the list that is played |
| lcd_data | output | 8 | Byte of the current entry |
| lcd_en | output | 1 | Enable strobe |
| done | output | 1 | High once the whole list has been sent |

## Verification
The only input the block has is reset, so the assertions assume just that reset is released cleanly between clock edges. The timing parameters must also meet the elaboration checks: every count at least one, and the long wait no shorter than the normal one. The bench changes reset only on falling clock edges, including the reset in the middle of the sequence. It uses small counts so that the exact strobe widths and gaps can be measured cycle by cycle against values computed from the parameters.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

   typedef enum logic [1:0] {
      PH_SETUP  = 2'd0,
      PH_STROBE = 2'd1,
      PH_SETTLE = 2'd2,
      PH_DONE   = 2'd3
   } lcdseq_phase_e;

   typedef struct packed {
      logic       rs_bit;
      logic       rw_bit;
      logic [7:0] payload;
   } lcdseq_word_t;

   localparam int unsigned INIT_WORDS = 4;

   localparam logic [7:0] OP_FUNC_SET = 8'h3C;
   localparam logic [7:0] OP_DISP_ON  = 8'h0C;
   localparam logic [7:0] OP_CLEAR    = 8'h01;
   localparam logic [7:0] OP_HOME     = 8'h02;
   localparam logic [7:0] OP_SHIFT_L  = 8'h18;

   localparam logic [1:0] PFX_INSTR = 2'b00;
   localparam logic [1:0] PFX_CHAR  = 2'b10;

endpackage

// File: rtl/lcdseq_table.sv
module lcdseq_table
   import lcdseq_pkg::*;
#(
   parameter int unsigned MSG_LEN    = 8,
   parameter logic [8*MSG_LEN-1:0] MSG = "READY GO",
   parameter bit          TAIL_SHIFT = 1'b1,
   parameter int unsigned PTR_W      = 4
) (
   input  logic [PTR_W-1:0] idx,
   output lcdseq_word_t     word,
   output logic             long_wait
);

   localparam int unsigned DEPTH = INIT_WORDS + MSG_LEN + (TAIL_SHIFT ? 1 : 0);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   lcdseq_word_t rom_w [DEPTH];

   assign rom_w[0] = {PFX_INSTR, OP_FUNC_SET};
   assign rom_w[1] = {PFX_INSTR, OP_DISP_ON};
   assign rom_w[2] = {PFX_INSTR, OP_CLEAR};
   assign rom_w[3] = {PFX_INSTR, OP_HOME};

   generate
      for (genvar k = 0; k < MSG_LEN; k++) begin : g_chr
         assign rom_w[INIT_WORDS + k] = {PFX_CHAR, MSG[8*(MSG_LEN-1-k) +: 8]};
      end
      if (TAIL_SHIFT) begin : g_tail
         assign rom_w[DEPTH-1] = {PFX_INSTR, OP_SHIFT_L};
      end
   endgenerate

   always_comb begin
      if (idx < PTR_W'(DEPTH)) word = rom_w[idx[IDX_W-1:0]];
      else                     word = '0;
   end

   // Clear and cursor-home instructions take the long wait
   assign long_wait = !word.rs_bit && (word.payload[7:2] == 6'd0) &&
                      (word.payload[1:0] != 2'd0);

endmodule

// File: rtl/lcdseq_timer.sv
module lcdseq_timer #(
   parameter int unsigned W    = 8,
   parameter int unsigned INIT = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= W'(INIT);
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R4 R7 R8: once expired the timer stays idle until reloaded
   timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired);

endmodule

// File: rtl/lcd_cmd_sequencer.sv
module lcd_cmd_sequencer
   import lcdseq_pkg::*;
#(
   parameter int unsigned SETUP_CYCLES       = 2,
   parameter int unsigned STROBE_CYCLES      = 12,
   parameter int unsigned SETTLE_CYCLES      = 2000,
   parameter int unsigned LONG_SETTLE_CYCLES = 82000,
   parameter int unsigned MSG_LEN            = 8,
   parameter logic [8*MSG_LEN-1:0] MSG       = "READY GO",
   parameter bit          TAIL_SHIFT         = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       lcd_rs,
   output logic       lcd_rw,
   output logic [7:0] lcd_data,
   output logic       lcd_en,
   output logic       done
);

   localparam int unsigned DEPTH   = INIT_WORDS + MSG_LEN + (TAIL_SHIFT ? 1 : 0);
   localparam int unsigned PTR_W   = $clog2(DEPTH + 1);
   localparam int unsigned END_IDX = DEPTH;
   localparam int unsigned LAST    = DEPTH - 1;
   localparam int unsigned MAX_A   = (STROBE_CYCLES > SETUP_CYCLES) ? STROBE_CYCLES : SETUP_CYCLES;
   localparam int unsigned MAX_B   = (LONG_SETTLE_CYCLES > SETTLE_CYCLES) ? LONG_SETTLE_CYCLES : SETTLE_CYCLES;
   localparam int unsigned CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (SETUP_CYCLES < 1 || STROBE_CYCLES < 1 || SETTLE_CYCLES < 1) begin : g_bad_cnt
         $error("lcd_cmd_sequencer: every phase count must be at least 1");
      end
      if (LONG_SETTLE_CYCLES < SETTLE_CYCLES) begin : g_bad_long
         $error("lcd_cmd_sequencer: long settle shorter than normal settle");
      end
      if (MSG_LEN < 1) begin : g_bad_msg
         $error("lcd_cmd_sequencer: message must hold at least one byte");
      end
   endgenerate

   lcdseq_phase_e    phase, phase_nx;
   logic [PTR_W-1:0] ptr, ptr_nx;
   logic             tmr_load, tmr_expired, long_wait;
   logic [CNT_W-1:0] tmr_val;
   lcdseq_word_t     cur;

   lcdseq_table #(
      .MSG_LEN    (MSG_LEN),
      .MSG        (MSG),
      .TAIL_SHIFT (TAIL_SHIFT),
      .PTR_W      (PTR_W)
   ) table_i (
      .idx       (ptr),
      .word      (cur),
      .long_wait (long_wait)
   );

   lcdseq_timer #(
      .W    (CNT_W),
      .INIT (SETUP_CYCLES - 1)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      phase_nx = phase;
      ptr_nx   = ptr;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (phase)
         PH_SETUP: if (tmr_expired) begin
            phase_nx = PH_STROBE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(STROBE_CYCLES - 1);
         end
         PH_STROBE: if (tmr_expired) begin
            phase_nx = PH_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = long_wait ? CNT_W'(LONG_SETTLE_CYCLES - 1)
                                 : CNT_W'(SETTLE_CYCLES - 1);
         end
         PH_SETTLE: if (tmr_expired) begin
            ptr_nx = ptr + 1'b1;
            if (ptr == PTR_W'(LAST)) begin
               phase_nx = PH_DONE;
            end else begin
               phase_nx = PH_SETUP;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SETUP_CYCLES - 1);
            end
         end
         default: phase_nx = PH_DONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_SETUP;
         ptr   <= '0;
      end else begin
         phase <= phase_nx;
         ptr   <= ptr_nx;
      end
   end

   assign lcd_rs   = cur.rs_bit;
   assign lcd_rw   = cur.rw_bit;
   assign lcd_data = cur.payload;
   assign lcd_en   = (phase == PH_STROBE);
   assign done     = (phase == PH_DONE);

   // R9
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_W'(END_IDX));

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !lcd_en);

   // R6
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en |=> (!lcd_en || ($stable(lcd_data) && $stable(lcd_rs) && $stable(lcd_rw))));

   // R5
   setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_en) |-> ($stable(lcd_data) && $stable(lcd_rs)));

endmodule

// File: tb/lcd_cmd_sequencer_tb.sv
module lcd_cmd_sequencer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SU  = 2;
   localparam int STB = 3;
   localparam int STL = 4;
   localparam int LNG = 9;
   localparam int NENT = 13;
   localparam int WATCHDOG = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lcd_rs, lcd_rw, lcd_en, done;
   logic [7:0] lcd_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_cmd_sequencer #(
      .SETUP_CYCLES       (SU),
      .STROBE_CYCLES      (STB),
      .SETTLE_CYCLES      (STL),
      .LONG_SETTLE_CYCLES (LNG),
      .MSG_LEN            (8),
      .MSG                ("READY GO"),
      .TAIL_SHIFT         (1'b1)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lcd_rs   (lcd_rs),
      .lcd_rw   (lcd_rw),
      .lcd_data (lcd_data),
      .lcd_en   (lcd_en),
      .done     (done)
   );

   function automatic logic [9:0] exp_word(int k);
      case (k)
         0:  return 10'h03C;
         1:  return 10'h00C;
         2:  return 10'h001;
         3:  return 10'h002;
         4:  return {2'b10, 8'h52};
         5:  return {2'b10, 8'h45};
         6:  return {2'b10, 8'h41};
         7:  return {2'b10, 8'h44};
         8:  return {2'b10, 8'h59};
         9:  return {2'b10, 8'h20};
         10: return {2'b10, 8'h47};
         11: return {2'b10, 8'h4F};
         default: return 10'h018;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary_and_end();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
         summary_and_end();
      end
   end

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Waits for a strobe, then measures its width and the low gap after it
   task automatic capture(output logic [9:0] w, output int width, output int gap,
                          output bit moved);
      moved = 1'b0;
      while (!lcd_en) @(negedge clk);
      w = {lcd_rs, lcd_rw, lcd_data};
      width = 0;
      while (lcd_en) begin
         if ({lcd_rs, lcd_rw, lcd_data} != w) moved = 1'b1;
         width++;
         @(negedge clk);
      end
      gap = 0;
      while (!lcd_en && !done) begin
         gap++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(lcd_en == 1'b0, "R1 en low in reset", lcd_en, 0);
      check(done == 1'b0, "R1 done low in reset", done, 0);
      check({lcd_rs, lcd_rw, lcd_data} == 10'h03C, "R1 first entry on bus",
            {lcd_rs, lcd_rw, lcd_data}, 10'h03C);
      rst_n = 1'b1;
      @(negedge clk);
      check(lcd_en == 1'b0 && done == 1'b0, "R1 R5 idle in setup after release",
            {done, lcd_en}, 0);
   endtask

   task automatic t_full_sequence();
      logic [9:0] w;
      int width, gap, exp_gap;
      bit moved;
      logic [9:0] ew;
      for (int k = 0; k < NENT; k++) begin
         capture(w, width, gap, moved);
         ew = exp_word(k);
         check(w == ew, $sformatf("R2 R3 entry %0d", k), w, ew);
         check(width == STB, $sformatf("R4 strobe width entry %0d", k), width, STB);
         check(!moved, $sformatf("R6 bus stable entry %0d", k), moved, 0);
         if (k == NENT - 1)
            exp_gap = STL;
         else if (ew[9] == 1'b0 && (ew[7:0] == 8'h01 || ew[7:0] == 8'h02))
            exp_gap = LNG + SU;
         else
            exp_gap = STL + SU;
         check(gap == exp_gap,
               $sformatf("%s gap entry %0d",
                         (k == NENT-1) ? "R9" : ((exp_gap == LNG + SU) ? "R8" : "R7 R5"), k),
               gap, exp_gap);
      end
      check(done == 1'b1, "R9 done after last entry", done, 1);
   endtask

   task automatic t_done_sticky();
      bit bad = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!done || lcd_en) bad = 1'b1;
      end
      check(!bad, "R9 done holds with en low", bad, 0);
   endtask

   task automatic t_midrun_reset();
      logic [9:0] w;
      int width, gap;
      bit moved;
      apply_reset();
      for (int k = 0; k < 5; k++) capture(w, width, gap, moved);
      while (!lcd_en) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(lcd_en == 1'b0 && done == 1'b0, "R10 quiet during reset", {done, lcd_en}, 0);
      check({lcd_rs, lcd_rw, lcd_data} == 10'h03C, "R10 pointer back at first entry",
            {lcd_rs, lcd_rw, lcd_data}, 10'h03C);
      rst_n = 1'b1;
      capture(w, width, gap, moved);
      check(w == 10'h03C, "R10 restart entry", w, 10'h03C);
      check(width == STB, "R10 restart strobe width", width, STB);
      check(gap == STL + SU, "R10 restart gap", gap, STL + SU);
      capture(w, width, gap, moved);
      check(w == 10'h00C, "R10 R3 second entry after restart", w, 10'h00C);
   endtask

   initial begin
      t_reset_state();
      t_full_sequence();
      t_done_sticky();
      t_midrun_reset();
      summary_and_end();
   end

endmodule